// File: doc/BRIEF.md
# Gated Index Pulse Generator

This block drives the reference-mark output of an incremental encoder interface. An interpolator upstream supplies the current quadrature step index within one signal period, together with its A and B levels. An external index sensor, already turned into a logic level by a comparator, supplies a gate that opens a window around one spot of the mechanical travel. Each time the step index enters the crossover increment while the window is open, the block emits a Z pulse that lasts exactly as long as the index stays in that increment. Because the crossover increment is fixed, Z keeps a fixed phase against A and B.

The gate is asynchronous to the block clock and goes through a synchronizer before use. The window level is taken once, at the moment of entry into the crossover increment, so that gate edges during a pulse do not chop it. A calibration select replaces the B output with the synchronized window, so the sensor threshold can be trimmed on a running system while Z keeps working. A disable input suppresses Z at once. A, B and Z all leave through one register stage, so their relative phase is preserved.

Top module: `zgen_index`

## Requirements
- R1: While `rst_n` is low, `z_out`, `a_out` and `b_out` are all 0.
- R2: When `step_idx` changes to `CROSS_IDX` (default 0) from any other value and the synchronized gate is 1, `z_out` goes to 1 one clock later. It stays 1 while `step_idx` holds `CROSS_IDX` and returns to 0 one clock after `step_idx` leaves it.
- R3: If the synchronized gate is 0 when `step_idx` enters `CROSS_IDX`, no pulse is produced for that visit, even if the gate rises while the index stays there.
- R4: A falling gate during a pulse does not shorten it. The pulse still ends only when `step_idx` leaves `CROSS_IDX`.
- R5: With the gate held at 1 and the index sweeping forward over several periods (`STEPS` = 20 increments, wrapping 19 to 0), exactly one pulse appears per period, in the increment at `CROSS_IDX`.
- R6: Entry from either side (from `CROSS_IDX`+1 moving backward or from `CROSS_IDX`-1 moving forward) produces a pulse. A reversal that takes the index back out of the increment ends the pulse one clock later.
- R7: While `pulse_dis` is 1, `z_out` is 0 one clock later. A pulse cut this way does not resume for the rest of that visit after `pulse_dis` returns to 0.
- R8: If `step_idx` already equals `CROSS_IDX` when reset is released, no pulse occurs until the index leaves and enters the increment again.
- R9: With `cal_en` = 1, `b_out` shows the gate level: a change on `gate_in` reaches `b_out` after the third rising clock edge, and `quad_b` has no effect on `b_out`. Z keeps working in this mode.
- R10: With `cal_en` = 0, `b_out` equals `quad_b` and `a_out` equals `quad_a` as sampled at the previous rising edge, regardless of the gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_in | input | 1 | Index gate from the sensor comparator, asynchronous |
| step_idx | input | $clog2(STEPS) | Quadrature step index within one period, 0 to STEPS-1 |
| quad_a | input | 1 | Interpolated A level |
| quad_b | input | 1 | Interpolated B level |
| cal_en | input | 1 | 1 selects the window onto `b_out` |
| pulse_dis | input | 1 | 1 forces Z low |
| z_out | output | 1 | Index pulse |
| a_out | output | 1 | A, registered |
| b_out | output | 1 | B or window, registered |

## Verification
A stale or wrongly captured window shows up on `z_out` within one clock of the entry into the crossover increment. It appears either as a pulse in a visit whose gate was closed or as a missing pulse in an open one. If the previous-index register holds a wrong value, pulses are doubled or lost on entry and after reset, and the bench catches this by checking every increment of several swept periods and by resetting at the crossover. A synchronizer with the wrong depth moves the calibration window on `b_out` by whole clocks, and the bench checks that window edge by edge.

// File: rtl/zgen_pkg.sv
package zgen_pkg;

    typedef enum logic {
        BSRC_QUAD   = 1'b0,
        BSRC_WINDOW = 1'b1
    } bsrc_e;

    typedef struct packed {
        logic a;
        logic b;
    } ab_out_s;

endpackage

// File: rtl/zgen_sync.sv
module zgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_d, sr_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sr_d = din;
        end else begin : g_chain
            always_comb sr_d = {sr_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/zgen_capture.sv
module zgen_capture #(
    parameter int STEP_W    = 5,
    parameter int CROSS_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_idx,
    input  logic              gate_sync,
    input  logic              pulse_dis,
    output logic [STEP_W-1:0] prev_step,
    output logic              fire
);
    localparam logic [STEP_W-1:0] CROSS_POS = STEP_W'(CROSS_IDX);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              fire;
    } cap_s;

    cap_s st_d, st_q;
    logic at_cross;
    logic entering;

    always_comb begin
        st_d      = st_q;
        st_d.step = step_idx;
        at_cross  = (step_idx == CROSS_POS);
        entering  = at_cross && (st_q.step != CROSS_POS);
        if (!at_cross || pulse_dis) begin
            st_d.fire = 1'b0;
        end else if (entering) begin
            st_d.fire = gate_sync;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{step: CROSS_POS, fire: 1'b0};
        else        st_q <= st_d;
    end

    assign prev_step = st_q.step;
    assign fire      = st_q.fire;
endmodule

// File: rtl/zgen_outmux.sv
module zgen_outmux
    import zgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic quad_a,
    input  logic quad_b,
    input  logic window,
    input  logic cal_en,
    output logic a_out,
    output logic b_out
);
    ab_out_s out_d, out_q;
    bsrc_e   bsrc;

    always_comb begin
        bsrc    = cal_en ? BSRC_WINDOW : BSRC_QUAD;
        out_d.a = quad_a;
        case (bsrc)
            BSRC_WINDOW: out_d.b = window;
            default:     out_d.b = quad_b;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign a_out = out_q.a;
    assign b_out = out_q.b;
endmodule

// File: rtl/zgen_index.sv
module zgen_index #(
    parameter int STEPS       = 20,
    parameter int CROSS_IDX   = 0,
    parameter int SYNC_STAGES = 2,
    parameter int STEP_W      = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_in,
    input  logic [STEP_W-1:0] step_idx,
    input  logic              quad_a,
    input  logic              quad_b,
    input  logic              cal_en,
    input  logic              pulse_dis,
    output logic              z_out,
    output logic              a_out,
    output logic              b_out
);
    logic              gate_sync;
    logic [STEP_W-1:0] prev_step;

    zgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (gate_in),
        .dout (gate_sync)
    );

    zgen_capture #(.STEP_W(STEP_W), .CROSS_IDX(CROSS_IDX)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_idx (step_idx),
        .gate_sync(gate_sync),
        .pulse_dis(pulse_dis),
        .prev_step(prev_step),
        .fire     (z_out)
    );

    zgen_outmux u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .quad_a(quad_a),
        .quad_b(quad_b),
        .window(gate_sync),
        .cal_en(cal_en),
        .a_out (a_out),
        .b_out (b_out)
    );
endmodule

// File: rtl/zgen_index_chk.sv
module zgen_index_chk #(
    parameter int STEP_W    = 5,
    parameter int CROSS_IDX = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STEP_W-1:0] step_idx,
    input logic [STEP_W-1:0] prev_step,
    input logic              gate_sync,
    input logic              pulse_dis,
    input logic              cal_en,
    input logic              quad_a,
    input logic              quad_b,
    input logic              z_out,
    input logic              a_out,
    input logic              b_out
);
    localparam logic [STEP_W-1:0] CP = STEP_W'(CROSS_IDX);
    logic started_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    always_comb begin
        if (!rst_n) assert_reset_quiet_R1: assert (!z_out && !a_out && !b_out);
    end

    assert_pulse_in_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && z_out) |-> ($past(step_idx) == CP));

    assert_rise_needs_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $rose(z_out)) |-> ($past(prev_step) != CP));

    assert_rise_needs_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $rose(z_out)) |-> $past(gate_sync));

    assert_disable_kills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(pulse_dis)) |-> !z_out);

    assert_cal_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(cal_en)) |-> (b_out == $past(gate_sync)));

    assert_b_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !$past(cal_en)) |-> (b_out == $past(quad_b)));

    assert_a_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (a_out == $past(quad_a)));
endmodule

bind zgen_index zgen_index_chk #(.STEP_W(STEP_W), .CROSS_IDX(CROSS_IDX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_idx (step_idx),
    .prev_step(prev_step),
    .gate_sync(gate_sync),
    .pulse_dis(pulse_dis),
    .cal_en   (cal_en),
    .quad_a   (quad_a),
    .quad_b   (quad_b),
    .z_out    (z_out),
    .a_out    (a_out),
    .b_out    (b_out)
);

// File: tb/zgen_index_test.sv
module zgen_index_test;
    localparam int CLK_PERIOD = 10;
    localparam int STEPS      = 20;
    localparam int STEP_W     = $clog2(STEPS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_in = 1'b0;
    logic [STEP_W-1:0] step_idx = '0;
    logic quad_a = 1'b0;
    logic quad_b = 1'b0;
    logic cal_en = 1'b0;
    logic pulse_dis = 1'b0;
    logic z_out, a_out, b_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zgen_index #(.STEPS(STEPS), .CROSS_IDX(0), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .step_idx(step_idx),
        .quad_a(quad_a), .quad_b(quad_b), .cal_en(cal_en), .pulse_dis(pulse_dis),
        .z_out(z_out), .a_out(a_out), .b_out(b_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step_to(input int p);
        step_idx = STEP_W'(p);
        tick();
    endtask

    task automatic open_gate();
        gate_in = 1'b1;
        repeat (3) tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        quad_a = 1'b1; quad_b = 1'b1; gate_in = 1'b1; step_idx = STEP_W'(5);
        tick(); tick();
        check("R1 z in reset", z_out, 1'b0);
        check("R1 a in reset", a_out, 1'b0);
        check("R1 b in reset", b_out, 1'b0);
        rst_n = 1'b1;
        quad_a = 1'b0; quad_b = 1'b0;
        tick(); tick(); tick();
    endtask

    task automatic t_basic();
        open_gate();
        step_to(18); step_to(19);
        check("R2 before entry", z_out, 1'b0);
        step_to(0);
        check("R2 on entry", z_out, 1'b1);
        tick();
        check("R2 while held", z_out, 1'b1);
        step_to(1);
        check("R2 after leaving", z_out, 1'b0);
    endtask

    task automatic t_reverse();
        open_gate();
        step_to(2); step_to(1); step_to(0);
        check("R6 backward entry", z_out, 1'b1);
        step_to(1);
        check("R6 reversal back out", z_out, 1'b0);
        step_to(0); step_to(19);
        check("R6 leave backward", z_out, 1'b0);
        step_to(0);
        check("R6 forward entry", z_out, 1'b1);
        step_to(19);
        check("R6 reversal to 19", z_out, 1'b0);
    endtask

    task automatic t_gate_low();
        gate_in = 1'b0;
        repeat (3) tick();
        step_to(19); step_to(0);
        check("R3 closed gate entry", z_out, 1'b0);
        gate_in = 1'b1;
        repeat (4) tick();
        check("R3 late gate ignored", z_out, 1'b0);
        step_to(1);
        check("R3 after leaving", z_out, 1'b0);
    endtask

    task automatic t_gate_drop();
        open_gate();
        step_to(19); step_to(0);
        check("R4 pulse start", z_out, 1'b1);
        gate_in = 1'b0;
        repeat (4) tick();
        check("R4 gate fell, pulse held", z_out, 1'b1);
        step_to(1);
        check("R4 end on leave", z_out, 1'b0);
    endtask

    task automatic t_periods();
        int pulses = 0;
        open_gate();
        step_to(1);
        for (int per = 0; per < 3; per++) begin
            for (int i = 2; i <= STEPS + 1; i++) begin
                step_to(i % STEPS);
                if (z_out) pulses++;
                check("R5 sweep", z_out, ((i % STEPS) == 0) ? 1'b1 : 1'b0);
            end
        end
        n_chk++;
        if (pulses != 3) begin
            n_bad++;
            $display("FAIL R5 pulse count: actual=%0d expected=3", pulses);
        end
    endtask

    task automatic t_disable();
        open_gate();
        step_to(19); step_to(0);
        check("R7 pulse before disable", z_out, 1'b1);
        pulse_dis = 1'b1;
        tick();
        check("R7 cut by disable", z_out, 1'b0);
        pulse_dis = 1'b0;
        tick(); tick();
        check("R7 no resume same visit", z_out, 1'b0);
        step_to(1);
        pulse_dis = 1'b1;
        step_to(0);
        check("R7 disabled entry", z_out, 1'b0);
        pulse_dis = 1'b0;
        step_to(1); step_to(0);
        check("R7 works again", z_out, 1'b1);
        step_to(1);
    endtask

    task automatic t_start_cross();
        gate_in = 1'b1;
        step_idx = STEP_W'(0);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        repeat (4) tick();
        check("R8 no pulse at startup", z_out, 1'b0);
        step_to(1); step_to(0);
        check("R8 pulse on re-entry", z_out, 1'b1);
        step_to(1);
    endtask

    task automatic t_cal();
        cal_en = 1'b1;
        gate_in = 1'b0;
        quad_b = 1'b1;
        repeat (3) tick();
        check("R9 window low, quad_b ignored", b_out, 1'b0);
        gate_in = 1'b1;
        tick();
        check("R9 edge 1", b_out, 1'b0);
        tick();
        check("R9 edge 2", b_out, 1'b0);
        tick();
        check("R9 edge 3", b_out, 1'b1);
        quad_b = 1'b0;
        tick();
        check("R9 quad_b low ignored", b_out, 1'b1);
        step_to(19); step_to(0);
        check("R9 Z in cal mode", z_out, 1'b1);
        step_to(1);
        gate_in = 1'b0;
        tick(); tick();
        check("R9 fall edge 2", b_out, 1'b1);
        tick();
        check("R9 fall edge 3", b_out, 1'b0);
        cal_en = 1'b0;
    endtask

    task automatic t_pass();
        cal_en = 1'b0;
        gate_in = 1'b1;
        quad_a = 1'b1; quad_b = 1'b0;
        tick();
        check("R10 a high", a_out, 1'b1);
        check("R10 b low with gate high", b_out, 1'b0);
        quad_a = 1'b0; quad_b = 1'b1;
        tick();
        check("R10 a low", a_out, 1'b0);
        check("R10 b high", b_out, 1'b1);
        gate_in = 1'b0;
        repeat (3) tick();
        check("R10 b unaffected by gate", b_out, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_reverse();
        t_gate_low();
        t_gate_drop();
        t_periods();
        t_disable();
        t_start_cross();
        t_cal();
        t_pass();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule